// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns eight already-selected input signals into eight interrupt requests, plus one combined request. Each channel is set up through a small word-wide register port: a mode bit picks edge or level sensitivity, and two enable registers change meaning with that bit. In edge mode they gate rising and falling edges. In level mode the first one gates the channel and the second one selects the active level.

Every input first passes through a two-flop synchronizer. An edge is seen when the synchronized value differs from the sample taken one clock earlier. In edge mode, an enabled edge sets a sticky status bit, and software clears it by writing a one to that bit. In level mode there is no latching: the request follows the synchronized input while it matches the selected level.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and no interrupt output is high, so all channels start in edge mode with interrupts disabled.
- R2: The mode register sits at offset 0x000. Bit n belongs to channel n: 0 selects edge mode and 1 selects level mode. Its value reads back as written.
- R3: Bits 31:8 of every register read as zero, and writes to them are ignored.
- R4: In edge mode, when bit n of the enable register at offset 0x004 is set, a rising edge on input n sets bit n of the rising-status register at offset 0x00C. The bit becomes visible after the third rising clock edge that follows the input change, and not after the second.
- R5: In edge mode, when bit n of the register at offset 0x008 is set, a falling edge on input n sets bit n of the falling-status register at offset 0x010.
- R6: A status bit stays set until a 1 is written to it. Writing a 0 leaves it unchanged.
- R7: In edge mode, an edge whose enable bit is 0 sets no status bit and raises no interrupt.
- R8: In level mode, the output for channel n is high exactly when bit n at offset 0x004 is set and the synchronized input equals bit n at offset 0x008 (1 means active HIGH, 0 means active LOW). The output follows the input with no latching.
- R9: In edge mode, the output for channel n is the OR of its rising-status and falling-status bits.
- R10: The combined output is the OR of all eight channel outputs.
- R11: Offsets outside the five mapped registers read as zero, and writes to them change no register.
- R12: A channel in level mode sets no status bit when its input has an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous channel inputs |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ch_irq | output | 8 | Per-channel interrupt requests |
| irq_any | output | 1 | OR of all channel requests |

## Verification
The table-driven run covers several setups. Rising edges and falling edges are each tried with all channels enabled and then with only half enabled, which separates the two enable registers and the edge direction each one gates. Level mode is tried with active-HIGH and active-LOW patterns, so the match is checked bit by bit rather than as a plain copy of the input. Mixed mode masks place edge and level channels side by side to show that the mode bit is decoded per channel. Directed tests then check the synchronizer latency cycle by cycle, write-0 against write-1 clearing, level mode with status frozen, reserved bits, and unmapped offsets.

// File: rtl/pin_irq_pkg.sv
// Shared constants for the pin interrupt controller.
// Assumes byte offsets on a word-aligned register port.
package pin_irq_pkg;
    localparam int CH_COUNT   = 8;
    localparam int OFS_W      = 8;
    localparam logic [OFS_W-1:0] OFS_MODE    = 8'h00;
    localparam logic [OFS_W-1:0] OFS_EN_A    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_EN_B    = 8'h08;
    localparam logic [OFS_W-1:0] OFS_ST_RISE = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_ST_FALL = 8'h10;
endpackage

// File: rtl/pin_irq_sync.sv
// Synchronizes a vector of asynchronous inputs through DEPTH flops and flags
// the changes between consecutive synchronized samples.
// Assumes DEPTH >= 2 and a synchronous active-low reset that clears all stages.
module pin_irq_sync #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise_pulse,
    output logic [W-1:0] fall_pulse
);
    logic [W-1:0] stage_q [DEPTH];
    logic [W-1:0] prev_q;

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    // Remaining stages form the shift chain.
    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Previous synchronized sample, used to find changes.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[DEPTH-1];
    end

    // Edge flags compare the current synchronized value with the previous one.
    always_comb begin
        sync_out   = stage_q[DEPTH-1];
        rise_pulse = sync_out & ~prev_q;
        fall_pulse = ~sync_out & prev_q;
    end
endmodule

// File: rtl/pin_irq_regs.sv
// Register file: mode, two enable registers, and read/write-one-to-clear status.
// Assumes one write per cycle. Reads are combinational from the address.
// Unmapped offsets read zero.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] rise_st,
    input  logic [NUM_CH-1:0] fall_st,
    output logic [NUM_CH-1:0] mode,
    output logic [NUM_CH-1:0] en_a,
    output logic [NUM_CH-1:0] en_b,
    output logic [NUM_CH-1:0] clr_rise,
    output logic [NUM_CH-1:0] clr_fall,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PAD_W = DATA_W - NUM_CH;

    logic [NUM_CH-1:0] wbits;
    logic              unused_hi;
    logic [NUM_CH-1:0] rsel;
    logic              hit_mode, hit_ena, hit_enb, hit_str, hit_stf;

    // Decode the offset against the register map.
    always_comb begin
        hit_mode  = (bus_addr == ADDR_W'(OFS_MODE));
        hit_ena   = (bus_addr == ADDR_W'(OFS_EN_A));
        hit_enb   = (bus_addr == ADDR_W'(OFS_EN_B));
        hit_str   = (bus_addr == ADDR_W'(OFS_ST_RISE));
        hit_stf   = (bus_addr == ADDR_W'(OFS_ST_FALL));
        wbits     = bus_wdata[NUM_CH-1:0];
        unused_hi = ^bus_wdata[DATA_W-1:NUM_CH];
    end

    // Control registers take the low bits of a write. Reserved bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            en_a <= '0;
            en_b <= '0;
        end else if (bus_wr) begin
            if (hit_mode) mode <= wbits;
            if (hit_ena)  en_a <= wbits;
            if (hit_enb)  en_b <= wbits;
        end
    end

    // Write-one-to-clear pulses for the status bits.
    always_comb begin
        clr_rise = (bus_wr && hit_str) ? wbits : '0;
        clr_fall = (bus_wr && hit_stf) ? wbits : '0;
    end

    // Read mux. Upper bits are always zero.
    always_comb begin
        rsel = '0;
        if (hit_mode) rsel = mode;
        if (hit_ena)  rsel = en_a;
        if (hit_enb)  rsel = en_b;
        if (hit_str)  rsel = rise_st;
        if (hit_stf)  rsel = fall_st;
        bus_rdata = {{PAD_W{1'b0}}, rsel};
    end
endmodule

// File: rtl/pin_irq_chan.sv
// One interrupt channel: sticky edge status in edge mode, and a direct level
// match in level mode.
// Assumes the edge pulses come from synchronized inputs. A set wins over a
// clear in the same cycle.
module pin_irq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic en_a,
    input  logic en_b,
    input  logic level,
    input  logic rise,
    input  logic fall,
    input  logic clr_rise,
    input  logic clr_fall,
    output logic rise_st,
    output logic fall_st,
    output logic irq
);
    // Sticky edge status, updated only while the channel is in edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_st <= 1'b0;
            fall_st <= 1'b0;
        end else begin
            rise_st <= (rise_st & ~clr_rise) | (rise & en_a & ~mode);
            fall_st <= (fall_st & ~clr_fall) | (fall & en_b & ~mode);
        end
    end

    // Request: status OR in edge mode, level match in level mode.
    always_comb begin
        if (mode) irq = en_a & (level == en_b);
        else      irq = rise_st | fall_st;
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
// Top of the pin interrupt controller: synchronizer, register file and one
// channel slice per input.
// Assumes pin_in is asynchronous and bus_* is synchronous to clk.
module pin_irq_ctrl #(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] ch_irq,
    output logic              irq_any
);
    logic [NUM_CH-1:0] sync_lvl, rise_p, fall_p;
    logic [NUM_CH-1:0] mode_q, en_a_q, en_b_q;
    logic [NUM_CH-1:0] clr_r, clr_f, st_r, st_f;

    pin_irq_sync #(.W(NUM_CH), .DEPTH(SYNC_DEPTH)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (pin_in),
        .sync_out   (sync_lvl),
        .rise_pulse (rise_p),
        .fall_pulse (fall_p)
    );

    pin_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rise_st   (st_r),
        .fall_st   (st_f),
        .mode      (mode_q),
        .en_a      (en_a_q),
        .en_b      (en_b_q),
        .clr_rise  (clr_r),
        .clr_fall  (clr_f),
        .bus_rdata (bus_rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pin_irq_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode_q[n]),
            .en_a     (en_a_q[n]),
            .en_b     (en_b_q[n]),
            .level    (sync_lvl[n]),
            .rise     (rise_p[n]),
            .fall     (fall_p[n]),
            .clr_rise (clr_r[n]),
            .clr_fall (clr_f[n]),
            .rise_st  (st_r[n]),
            .fall_st  (st_f[n]),
            .irq      (ch_irq[n])
        );
    end

    // Combined request across all channels.
    always_comb irq_any = |ch_irq;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
// Property checker for pin_irq_ctrl, attached by bind. It observes ports and
// internal register state and drives nothing.
module pin_irq_ctrl_chk
    import pin_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] mode,
    input logic [NUM_CH-1:0] en_a,
    input logic [NUM_CH-1:0] st_r,
    input logic [NUM_CH-1:0] st_f,
    input logic [NUM_CH-1:0] ch_irq,
    input logic              irq_any
);
    // R10: combined output tracks the channel vector
    p_any_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (ch_irq != '0));

    // R3: reserved read bits are zero
    p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_CH] == '0);

    // R2: mode holds unless written at its offset
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_MODE)) |=> $stable(mode));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R6: a rising status bit stays set without a write-one clear
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_r[n] && !(bus_wr && bus_addr == ADDR_W'(OFS_ST_RISE) && bus_wdata[n]))
            |=> st_r[n]);

        // R12: status only rises while the channel was in edge mode
        p_no_lvl_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(st_r[n]) || $rose(st_f[n])) |-> !$past(mode[n]));

        // R8: a disabled level channel never requests
        p_lvl_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[n] && !en_a[n]) |-> !ch_irq[n]);
    end
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode      (mode_q),
    .en_a      (en_a_q),
    .st_r      (st_r),
    .st_f      (st_f),
    .ch_irq    (ch_irq),
    .irq_any   (irq_any)
);

// File: tb/pin_irq_ctrl_tb_top.sv
// Self-checking bench for pin_irq_ctrl: a vector table, then directed tests.
module pin_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ch_irq;
    logic        irq_any;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pin_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_irq(ch_irq), .irq_any(irq_any)
    );

    // Entry fields: mode, enable A, enable B, pin before, pin after, expected irq.
    localparam logic [47:0] VEC [8] = '{
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF},  // R4 all rising
        {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF},  // R5 all falling
        {8'h00, 8'h0F, 8'hF0, 8'h00, 8'hFF, 8'h0F},  // R7 half rising enabled
        {8'h00, 8'hF0, 8'h0F, 8'hFF, 8'h00, 8'h0F},  // R7 half falling enabled
        {8'hFF, 8'hFF, 8'hAA, 8'h00, 8'h0F, 8'h5A},  // R8 mixed active level
        {8'hFF, 8'h33, 8'h00, 8'hFF, 8'h3C, 8'h03},  // R8 active low
        {8'h0F, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF},  // R9 mixed modes
        {8'hAA, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h55}   // R9 mixed, level low idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_pin(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(8'(a * 4), r);
            check("R1 reg reset", r, 32'h0);
        end
        check("R1 irq reset", {23'h0, irq_any, ch_irq}, 32'h0);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            logic [47:0] e;
            e = VEC[v];
            wr(8'h04, 32'h0);
            wr(8'h08, 32'h0);
            drive_pin(e[23:16]);
            wait_cyc(4);
            wr(8'h00, {24'h0, e[47:40]});
            wr(8'h04, {24'h0, e[39:32]});
            wr(8'h08, {24'h0, e[31:24]});
            wr(8'h0C, 32'hFF);
            wr(8'h10, 32'hFF);
            drive_pin(e[15:8]);
            wait_cyc(4);
            check($sformatf("R4 R5 R7 R8 R9 vec %0d ch_irq", v), {24'h0, ch_irq}, {24'h0, e[7:0]});
            check($sformatf("R10 vec %0d irq_any", v), {31'h0, irq_any}, {31'h0, (e[7:0] != 0)});
        end

        // R2 mode readback
        wr(8'h04, 32'h0); wr(8'h08, 32'h0);
        wr(8'h00, 32'h5A);
        rd(8'h00, r); check("R2 mode readback", r, 32'h5A);
        // R3 reserved bits
        wr(8'h00, 32'hFFFF_FF3C);
        rd(8'h00, r); check("R3 reserved ignored", r, 32'h3C);
        // R11 unmapped offset
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, r); check("R11 unmapped reads zero", r, 32'h0);
        rd(8'h00, r); check("R11 mode untouched", r, 32'h3C);
        rd(8'h04, r); check("R11 enable untouched", r, 32'h0);

        // R4 latency, channel 0 edge rising
        wr(8'h00, 32'h0);
        drive_pin(8'h00); wait_cyc(4);
        wr(8'h0C, 32'hFF); wr(8'h10, 32'hFF);
        wr(8'h04, 32'h01);
        @(negedge clk) pin_in = 8'h01;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_addr = 8'h0C; #1 check("R4 not yet after two edges", bus_rdata, 32'h0);
        @(posedge clk); @(negedge clk);
        #1 check("R4 set after third edge", bus_rdata, 32'h1);

        // R6 sticky: write 0 keeps, write 1 clears
        wr(8'h0C, 32'h0);
        rd(8'h0C, r); check("R6 write zero keeps", r, 32'h1);
        check("R9 irq from status", {31'h0, ch_irq[0]}, 32'h1);
        wr(8'h0C, 32'h1);
        rd(8'h0C, r); check("R6 write one clears", r, 32'h0);
        check("R6 irq cleared", {24'h0, ch_irq}, 32'h0);

        // R12 level mode sets no status on edges
        wr(8'h00, 32'hFF); wr(8'h04, 32'hFF); wr(8'h08, 32'hFF);
        drive_pin(8'h00); wait_cyc(4);
        drive_pin(8'hFF); wait_cyc(4);
        drive_pin(8'h00); wait_cyc(4);
        rd(8'h0C, r); check("R12 no rise status", r, 32'h0);
        rd(8'h10, r); check("R12 no fall status", r, 32'h0);
        check("R8 level released", {24'h0, ch_irq}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule